// File: doc/BRIEF.md
# 40-bit Multiply-Accumulate Unit

This datapath block multiplies two 16-bit operands and then adds the product to a 40-bit accumulator value, or subtracts it from that value. The caller chooses, for each operation, how the operands are interpreted: both signed, first signed and second unsigned, or both unsigned. Before the accumulate step, the accumulator value can be shifted arithmetically right by 1 bit or by 16 bits. This supports scaled accumulation and double-precision partial sums.

The product needs 32 bits. The eight bits above it are headroom, so a long run of products can be summed without losing the sign. An overflow flag is set whenever an exact result does not fit in 40-bit two's complement. The flag then stays set until the caller clears it. Each operation is presented with a one-cycle valid strobe. The result and a result-valid pulse appear from registers one clock later. Register selection and instruction decode are done outside the block.

Top module: `mac40_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `result` to zero and clears `out_valid` and `ovf_flag`.
- R2: An operation presented with `in_valid` high sets `out_valid` high one clock later and updates `result` at the same edge. When `in_valid` is low, `out_valid` is low one clock later and `result` keeps its value.
- R3: `sgn_mode` = 2'b00 treats both operands as two's complement. The product is sign-extended to 40 bits.
- R4: `sgn_mode` = 2'b01 treats `op_a` as two's complement and `op_b` as unsigned.
- R5: `sgn_mode` = 2'b10 and 2'b11 both treat the two operands as unsigned. The product is zero-extended.
- R6: With `do_sub` = 1 the result is accumulator minus product. With `do_sub` = 0 it is accumulator plus product.
- R7: `pre_shift` = 2'b01 shifts the accumulator input arithmetically right by 1 bit before the accumulate step, copying in the sign bit.
- R8: `pre_shift` = 2'b10 shifts the accumulator input arithmetically right by 16 bits. The codes 2'b00 and 2'b11 leave it unshifted.
- R9: When the exact result lies outside [-2^39, 2^39-1], `result` holds its low 40 bits and `ovf_flag` is set.
- R10: Once set, `ovf_flag` stays set through operations that do not overflow and through idle cycles.
- R11: `ovf_clear` high clears `ovf_flag` at the next edge. If an overflowing operation arrives in the same cycle, the flag ends up set.
- R12: 256 successive accumulations of the largest signed×signed product, 0x8000×0x8000, starting from zero, give 2^38 with `ovf_flag` still clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 16 | First multiplier operand |
| op_b | input | 16 | Second multiplier operand |
| acc_in | input | 40 | Accumulator operand |
| sgn_mode | input | 2 | Operand signedness select (R3 to R5) |
| do_sub | input | 1 | 1 = subtract product, 0 = add product |
| pre_shift | input | 2 | Accumulator pre-shift select (R7, R8) |
| ovf_clear | input | 1 | Clear for the sticky overflow flag |
| out_valid | output | 1 | Result-valid pulse |
| result | output | 40 | Registered accumulate result |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench drives operands of 0x8000 and 0xFFFF in each signedness mode. A design that sign-extends an unsigned operand, or the reverse, returns a product with the wrong sign or magnitude.

It applies both shifts to negative accumulators. A logical shift in place of an arithmetic one would turn those values into large positive ones.

Overflow is provoked at the positive edge of the range with an add and at the negative edge with a subtract. The bench then checks that the flag stays set, and it tests a clear that arrives alongside an overflowing operation. A design with a non-sticky flag, or with the wrong priority between clear and set, shows a flag value that differs from the bench's model.

A run of 256 chained maximum products uses the guard bits. An adder that is too narrow, or an overflow test made on bit 31, fails that run.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  typedef enum logic [1:0] {
    SGN_SS  = 2'b00,
    SGN_SU  = 2'b01,
    SGN_UU  = 2'b10,
    SGN_UU2 = 2'b11
  } sgn_e;

  typedef enum logic [1:0] {
    SHF_NONE = 2'b00,
    SHF_LO   = 2'b01,
    SHF_HI   = 2'b10,
    SHF_RSV  = 2'b11
  } shf_e;
endpackage

// File: rtl/mac40_mult.sv
module mac40_mult #(
  parameter int W_OP  = 16,
  parameter int W_ACC = 40
) (
  input  logic [W_OP-1:0]   a,
  input  logic [W_OP-1:0]   b,
  input  mac40_pkg::sgn_e   mode,
  output logic [W_ACC-1:0]  prod
);
  localparam int WX = W_OP + 1;
  localparam int WP = 2 * WX;

  logic a_sgn, b_sgn;
  logic signed [WX-1:0] ax, bx;
  logic signed [WP-1:0] p;

  always_comb begin
    unique case (mode)
      mac40_pkg::SGN_SS: begin a_sgn = 1'b1; b_sgn = 1'b1; end
      mac40_pkg::SGN_SU: begin a_sgn = 1'b1; b_sgn = 1'b0; end
      default:           begin a_sgn = 1'b0; b_sgn = 1'b0; end
    endcase
  end

  // one extra bit per operand makes every mode a signed multiply
  assign ax = {a_sgn & a[W_OP-1], a};
  assign bx = {b_sgn & b[W_OP-1], b};
  assign p  = ax * bx;

  generate
    if (W_ACC > WP) begin : g_ext
      assign prod = {{(W_ACC-WP){p[WP-1]}}, p};
    end else begin : g_trunc
      assign prod = p[W_ACC-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac40_preshift.sv
module mac40_preshift #(
  parameter int W_ACC = 40,
  parameter int SH_LO = 1,
  parameter int SH_HI = 16
) (
  input  logic [W_ACC-1:0] acc,
  input  mac40_pkg::shf_e  sel,
  output logic [W_ACC-1:0] acc_sh
);
  logic signed [W_ACC-1:0] s_acc;
  assign s_acc = $signed(acc);

  always_comb begin
    unique case (sel)
      mac40_pkg::SHF_LO: acc_sh = W_ACC'(s_acc >>> SH_LO);
      mac40_pkg::SHF_HI: acc_sh = W_ACC'(s_acc >>> SH_HI);
      default:           acc_sh = acc;
    endcase
  end
endmodule

// File: rtl/mac40_accum.sv
module mac40_accum #(
  parameter int W_ACC = 40
) (
  input  logic [W_ACC-1:0] acc,
  input  logic [W_ACC-1:0] prod,
  input  logic             sub,
  output logic [W_ACC-1:0] sum,
  output logic             ovf
);
  localparam int WS = W_ACC + 1;

  logic [WS-1:0] ae, pe, se;

  assign ae  = {acc[W_ACC-1], acc};
  assign pe  = {prod[W_ACC-1], prod};
  assign se  = sub ? (ae - pe) : (ae + pe);
  assign sum = se[W_ACC-1:0];
  // top two bits disagree exactly when the result leaves the signed range
  assign ovf = se[WS-1] ^ se[W_ACC-1];
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit #(
  parameter int W_OP  = 16,
  parameter int W_ACC = 40,
  parameter int SH_LO = 1,
  parameter int SH_HI = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [15:0]      op_a,
  input  logic [15:0]      op_b,
  input  logic [39:0]      acc_in,
  input  logic [1:0]       sgn_mode,
  input  logic             do_sub,
  input  logic [1:0]       pre_shift,
  input  logic             ovf_clear,
  output logic             out_valid,
  output logic [39:0]      result,
  output logic             ovf_flag
);
  logic [W_ACC-1:0] prod_w, acc_sh_w, sum_w;
  logic             ovf_w;

  mac40_mult #(.W_OP(W_OP), .W_ACC(W_ACC)) u_mult (
    .a    (op_a[W_OP-1:0]),
    .b    (op_b[W_OP-1:0]),
    .mode (mac40_pkg::sgn_e'(sgn_mode)),
    .prod (prod_w)
  );

  mac40_preshift #(.W_ACC(W_ACC), .SH_LO(SH_LO), .SH_HI(SH_HI)) u_shf (
    .acc    (acc_in[W_ACC-1:0]),
    .sel    (mac40_pkg::shf_e'(pre_shift)),
    .acc_sh (acc_sh_w)
  );

  mac40_accum #(.W_ACC(W_ACC)) u_acc (
    .acc  (acc_sh_w),
    .prod (prod_w),
    .sub  (do_sub),
    .sum  (sum_w),
    .ovf  (ovf_w)
  );

  logic [W_ACC-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res_q <= sum_w;
      ovf_flag  <= (ovf_flag & ~ovf_clear) | (in_valid & ovf_w);
    end
  end

  assign result = res_q[39:0];
endmodule

// File: rtl/mac40_chk.sv
module mac40_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        ovf_clear,
  input logic        out_valid,
  input logic [39:0] result,
  input logic        ovf_flag
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_result_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clear) |=> ovf_flag);
  assert_flag_cleared_R11: assert property (@(posedge clk) disable iff (rst)
    (ovf_clear && !in_valid) |=> !ovf_flag);
  assert_no_spurious_set_R9: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && !in_valid) |=> !ovf_flag);
endmodule

bind mac40_unit mac40_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .ovf_clear (ovf_clear),
  .out_valid (out_valid),
  .result    (result),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_mac40_unit.sv
module sim_mac40_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [39:0] acc_in = '0;
  logic [1:0]  sgn_mode = '0, pre_shift = '0;
  logic        do_sub = 1'b0, ovf_clear = 1'b0;
  logic        out_valid, ovf_flag;
  logic [39:0] result;

  int n_chk = 0, n_bad = 0;
  logic exp_ovf = 1'b0;

  always #10 clk = ~clk;

  mac40_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_in(acc_in), .sgn_mode(sgn_mode), .do_sub(do_sub),
    .pre_shift(pre_shift), .ovf_clear(ovf_clear),
    .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: wide signed arithmetic and a range compare
  task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [39:0] acc,
                       input logic [1:0] m, input logic s, input logic [1:0] sh,
                       output logic [39:0] res, output logic ov);
    logic signed [63:0] av, bv, cv, sum;
    av = (m == 2'b00 || m == 2'b01) ? 64'($signed(a)) : {48'd0, a};
    bv = (m == 2'b00) ? 64'($signed(b)) : {48'd0, b};
    cv = 64'($signed(acc));
    if (sh == 2'b01) cv = cv / 2 - ((cv < 0 && cv[0]) ? 64'sd1 : 64'sd0);
    else if (sh == 2'b10) cv = cv >>> 16;
    sum = s ? cv - av * bv : cv + av * bv;
    ov  = (sum > 64'sh7F_FFFF_FFFF) || (sum < -64'sh80_0000_0000);
    res = sum[39:0];
  endtask

  task automatic op(input string req, input logic [15:0] a, input logic [15:0] b,
                    input logic [39:0] acc, input logic [1:0] m, input logic s,
                    input logic [1:0] sh, input logic clr);
    logic [39:0] er; logic eo;
    model(a, b, acc, m, s, sh, er, eo);
    @(negedge clk);
    op_a = a; op_b = b; acc_in = acc; sgn_mode = m; do_sub = s;
    pre_shift = sh; ovf_clear = clr; in_valid = 1'b1;
    exp_ovf = (exp_ovf & ~clr) | eo;
    @(negedge clk);
    in_valid = 1'b0; ovf_clear = 1'b0;
    check({req, " result"}, result, er);
    check({req, " out_valid R2"}, {39'd0, out_valid}, 40'd1);
    check({req, " ovf_flag"}, {39'd0, ovf_flag}, {39'd0, exp_ovf});
  endtask

  task automatic t_reset;
    check("R1 result", result, 40'd0);
    check("R1 out_valid", {39'd0, out_valid}, 40'd0);
    check("R1 ovf_flag", {39'd0, ovf_flag}, 40'd0);
  endtask

  task automatic t_modes;
    op("R3 ss neg", 16'h8000, 16'h0003, 40'd100, 2'b00, 1'b0, 2'b00, 1'b0);
    op("R3 ss max", 16'h8000, 16'h8000, 40'd0, 2'b00, 1'b0, 2'b00, 1'b0);
    op("R4 su", 16'hFFFF, 16'hFFFF, 40'd0, 2'b01, 1'b0, 2'b00, 1'b0);
    op("R4 su pos", 16'h1234, 16'h8001, 40'd7, 2'b01, 1'b0, 2'b00, 1'b0);
    op("R5 uu", 16'hFFFF, 16'hFFFF, 40'd0, 2'b10, 1'b0, 2'b00, 1'b0);
    op("R5 uu code3", 16'h8000, 16'hFFFF, 40'd1, 2'b11, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_sub_shift;
    op("R6 sub", 16'h0010, 16'h0020, 40'd1000, 2'b00, 1'b1, 2'b00, 1'b0);
    op("R6 sub neg", 16'hFFFF, 16'h0005, 40'hFF_FFFF_FFF0, 2'b00, 1'b1, 2'b00, 1'b0);
    op("R7 shift1 neg", 16'h0002, 16'h0003, 40'hF0_0000_0003, 2'b00, 1'b0, 2'b01, 1'b0);
    op("R8 shift16 neg", 16'h0001, 16'h0001, 40'h80_1234_5678, 2'b00, 1'b0, 2'b10, 1'b0);
    op("R8 code3 none", 16'h0001, 16'h0001, 40'h80_1234_5678, 2'b00, 1'b0, 2'b11, 1'b0);
  endtask

  task automatic t_hold;
    logic [39:0] keep;
    keep = result;
    repeat (3) @(negedge clk);
    check("R2 hold result", result, keep);
    check("R2 idle out_valid", {39'd0, out_valid}, 40'd0);
  endtask

  task automatic t_overflow;
    op("R9 pos ovf", 16'h0001, 16'h0001, 40'h7F_FFFF_FFFF, 2'b00, 1'b0, 2'b00, 1'b0);
    op("R10 sticky", 16'h0001, 16'h0001, 40'd0, 2'b00, 1'b0, 2'b00, 1'b0);
    repeat (2) @(negedge clk);
    check("R10 sticky idle", {39'd0, ovf_flag}, 40'd1);
    @(negedge clk); ovf_clear = 1'b1;
    @(negedge clk); ovf_clear = 1'b0; exp_ovf = 1'b0;
    check("R11 clear", {39'd0, ovf_flag}, 40'd0);
    op("R9 neg ovf", 16'h0001, 16'h0001, 40'h80_0000_0000, 2'b00, 1'b1, 2'b00, 1'b0);
    op("R11 clear+ovf", 16'h0002, 16'h0001, 40'h80_0000_0000, 2'b00, 1'b1, 2'b00, 1'b1);
    op("R11 clear+ok", 16'h0002, 16'h0001, 40'd0, 2'b00, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic t_guard;
    logic [39:0] acc;
    acc = '0;
    for (int i = 0; i < 256; i++) begin
      op("R12 guard", 16'h8000, 16'h8000, acc, 2'b00, 1'b0, 2'b00, 1'b0);
      acc = result;
    end
    check("R12 final", acc, 40'h40_0000_0000);
    check("R12 no ovf", {39'd0, ovf_flag}, 40'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_modes();
    t_sub_shift();
    t_hold();
    t_overflow();
    t_guard();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule